// File: doc/BRIEF.md
# Swipe-Sensor Frame Sync and Heater Pulse Controller

This block sits behind the digital output of a swipe fingerprint sensor that delivers a frame as a fixed-length run of bytes, each byte carrying two 4-bit pixels (odd pixel in the upper nibble, even pixel in the lower nibble). At the end of every frame the sensor emits a short marker column: two bytes with a fixed bit pattern, then a byte whose lower nibble is a coded chip temperature delta, then one more byte. The block hunts for the marker pair in the raw stream, confirms that it repeats at the exact frame spacing, and then reports a lock flag and the position of the next byte within the frame, so that downstream logic can slice pixels into columns without a pattern search of its own.

Once locked, the block picks up the temperature-delta code from each frame. Code 8 stands for no change, each step is roughly 1.4 K, and codes 0 and 15 are the saturated ends. When the image pipeline flags poor contrast, the block fires a single bounded heater-enable pulse that aims to lift the code by two steps, and it ends the pulse early when that rise is seen, when the code saturates, or when lock is lost.

Top module: `sweep_sync_thermal`

## Requirements
- R1: A byte is a marker byte when bits [7:5] are 111 and bits [3:0] are 0000; bit 4 is ignored. While searching, two consecutive accepted marker bytes form a pair, and the byte after the second one takes index FRAME_LEN-2 (1122 by default), so `byteIdx` reads 0 after the frame's final byte.
- R2: Lock is declared on the byte that completes the `lockFrames`-th consecutive pair found at exactly FRAME_LEN-byte spacing (a value of 0 behaves as 1); a missing pair during this confirmation sends the block back to searching with the count cleared.
- R3: While locked, only the predicted pair position (indices FRAME_LEN-4 and FRAME_LEN-3) is examined; marker bytes elsewhere in the frame change neither the lock flag nor the index.
- R4: `byteIdx` advances by one on each accepted byte (`byteValid` high), wraps from FRAME_LEN-1 to 0, and holds on cycles with `byteValid` low.
- R5: While locked, the lower nibble of the byte at index FRAME_LEN-2 is loaded into `tempCode` one cycle after it is accepted, with `tempValid` high for exactly that cycle; `tempValid` is never high while unlocked.
- R6: While locked, each missing pair at the predicted position counts a miss and a found pair clears the count; reaching `missLimit` consecutive misses (0 behaves as 1) drops lock and restarts the search.
- R7: While locked and the heater is off, a `tempValid` cycle with `lowContrast` high, a code from 0 to 13 and a non-zero pulse limit raises `heatEn` on the next cycle; the goal is the captured code plus 2.
- R8: The pulse limit is the smaller of `heatOnTime` and MAX_ON clock cycles; `heatEn` stays high for at most that many cycles, and falls one cycle after a `tempValid` whose code reaches the goal or equals 15.
- R9: A code of 14 or 15 never starts a pulse; whenever lock is low, `heatEn` is low on the next cycle and no pulse starts.
- R10: After reset, `locked` is 0, `byteIdx` is 0, `tempCode` is 8, `tempValid` is 0 and `heatEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | Qualifies `byteIn` for this cycle |
| byteIn | input | 8 | Sensor byte: odd pixel in [7:4], even pixel in [3:0] |
| lockFrames | input | CNT_W | Consecutive pairs needed to declare lock |
| missLimit | input | CNT_W | Consecutive misses that drop lock |
| lowContrast | input | 1 | Contrast-at-risk request from the image pipeline |
| heatOnTime | input | TIME_W | Requested heater pulse length in cycles |
| locked | output | 1 | Frame alignment is locked |
| byteIdx | output | IW | Index the next accepted byte will take in the frame |
| tempCode | output | 4 | Latest temperature-delta code |
| tempValid | output | 1 | One-cycle strobe when `tempCode` is refreshed |
| heatEn | output | 1 | Heater enable pulse |

## Verification
On every cycle the assertions hold the invariants that need no scenario: the heater is forced off one cycle after lock is low, a temperature strobe never appears without lock, the index holds on idle cycles and steps with wrap while locked, and no heater pulse outlasts MAX_ON. Whether lock is reached after exactly the right number of frames, survives a single miss but not `missLimit` of them, ignores a decoy pattern mid-frame, and whether a pulse ends on a two-step rise rather than on its timer, can only be shown by the bench's frame sequences compared against its cycle model.

// File: rtl/sweep_sync_pkg.sv
`timescale 1ns/1ps
package sweep_sync_pkg;

  typedef enum logic [1:0] {
    SYNC_SEARCH = 2'd0,
    SYNC_VERIFY = 2'd1,
    SYNC_LOCKED = 2'd2
  } syncState_t;

  typedef struct packed {
    logic reSync;   // realign index: next byte is the temperature byte
    logic capTemp;  // load the current byte's lower nibble as temperature
  } syncStrobe_t;

endpackage

// File: rtl/sync_datapath.sv
`timescale 1ns/1ps
module sync_datapath
  import sweep_sync_pkg::*;
#(
  parameter int FRAME_LEN = 1124,
  parameter int IW        = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteValid,
  input  logic [7:0]    byteIn,
  input  syncStrobe_t   strobe,
  output logic          matchNow,
  output logic          prevSync,
  output logic [IW-1:0] curIdx,
  output logic [3:0]    tempCode,
  output logic          tempValid
);

  localparam logic [IW-1:0] IDX_LAST   = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] IDX_RELOAD = IW'(FRAME_LEN - 2);

  logic [IW-1:0] idxReg;

  assign matchNow = (byteIn[7:5] == 3'b111) && (byteIn[3:0] == 4'h0);
  assign curIdx   = idxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg    <= '0;
      prevSync  <= 1'b0;
      tempCode  <= 4'd8;
      tempValid <= 1'b0;
    end else begin
      tempValid <= strobe.capTemp;
      if (byteValid) begin
        prevSync <= matchNow;
        if (strobe.reSync)
          idxReg <= IDX_RELOAD;
        else if (idxReg == IDX_LAST)
          idxReg <= '0;
        else
          idxReg <= idxReg + 1'b1;
        if (strobe.capTemp)
          tempCode <= byteIn[3:0];
      end
    end
  end

endmodule

// File: rtl/sync_control.sv
`timescale 1ns/1ps
module sync_control
  import sweep_sync_pkg::*;
#(
  parameter int FRAME_LEN = 1124,
  parameter int IW        = $clog2(FRAME_LEN),
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             matchNow,
  input  logic             prevSync,
  input  logic [IW-1:0]    curIdx,
  input  logic [CNT_W-1:0] lockFrames,
  input  logic [CNT_W-1:0] missLimit,
  output syncStrobe_t      strobe,
  output logic             locked
);

  localparam logic [IW-1:0]  IDX_CHECK = IW'(FRAME_LEN - 3);
  localparam logic [IW-1:0]  IDX_TEMP  = IW'(FRAME_LEN - 2);
  localparam logic [CNT_W:0] ONE       = (CNT_W+1)'(1);

  syncState_t       state, stateNxt;
  logic [CNT_W-1:0] hitCnt, hitCntNxt, missCnt, missCntNxt;
  logic [CNT_W:0]   hitTarget, missTarget;
  logic             pairHit, atCheck, atTemp;

  assign hitTarget  = (lockFrames == '0) ? ONE : {1'b0, lockFrames};
  assign missTarget = (missLimit  == '0) ? ONE : {1'b0, missLimit};
  assign pairHit    = byteValid && matchNow && prevSync;
  assign atCheck    = byteValid && (curIdx == IDX_CHECK);
  assign atTemp     = byteValid && (curIdx == IDX_TEMP);
  assign locked     = (state == SYNC_LOCKED);

  always_comb begin
    stateNxt   = state;
    hitCntNxt  = hitCnt;
    missCntNxt = missCnt;
    strobe     = '0;
    unique case (state)
      SYNC_SEARCH: begin
        if (pairHit) begin
          strobe.reSync = 1'b1;
          if (hitTarget <= ONE) begin
            stateNxt   = SYNC_LOCKED;
            missCntNxt = '0;
          end else begin
            stateNxt  = SYNC_VERIFY;
            hitCntNxt = CNT_W'(1);
          end
        end
      end
      SYNC_VERIFY: begin
        if (atCheck) begin
          if (!pairHit) begin
            stateNxt = SYNC_SEARCH;
          end else if (({1'b0, hitCnt} + ONE) >= hitTarget) begin
            stateNxt   = SYNC_LOCKED;
            missCntNxt = '0;
          end else begin
            hitCntNxt = hitCnt + 1'b1;
          end
        end
      end
      SYNC_LOCKED: begin
        strobe.capTemp = atTemp;
        if (atCheck) begin
          if (pairHit)
            missCntNxt = '0;
          else if (({1'b0, missCnt} + ONE) >= missTarget)
            stateNxt = SYNC_SEARCH;
          else
            missCntNxt = missCnt + 1'b1;
        end
      end
      default: stateNxt = SYNC_SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SYNC_SEARCH;
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      state   <= stateNxt;
      hitCnt  <= hitCntNxt;
      missCnt <= missCntNxt;
    end
  end

endmodule

// File: rtl/heater_pulse.sv
`timescale 1ns/1ps
module heater_pulse #(
  parameter int TIME_W = 16,
  parameter int MAX_ON = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locked,
  input  logic              tempValid,
  input  logic [3:0]        tempCode,
  input  logic              lowContrast,
  input  logic [TIME_W-1:0] heatOnTime,
  output logic              heatEn
);

  localparam logic [TIME_W-1:0] MAX_ON_W  = TIME_W'(MAX_ON);
  localparam logic [3:0]        TOP_START = 4'd13;
  localparam logic [3:0]        CODE_SAT  = 4'd15;

  logic [TIME_W-1:0] limit, timer;
  logic [4:0]        goal;
  logic              canStart, stopNow;

  assign limit    = (heatOnTime > MAX_ON_W) ? MAX_ON_W : heatOnTime;
  assign canStart = tempValid && lowContrast && (tempCode <= TOP_START) && (limit != '0);
  assign stopNow  = (tempValid && (({1'b0, tempCode} >= goal) || (tempCode == CODE_SAT)))
                 || (timer >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heatEn <= 1'b0;
      timer  <= '0;
      goal   <= '0;
    end else if (!locked) begin
      heatEn <= 1'b0;
      timer  <= '0;
    end else if (!heatEn) begin
      if (canStart) begin
        heatEn <= 1'b1;
        timer  <= TIME_W'(1);
        goal   <= {1'b0, tempCode} + 5'd2;
      end
    end else if (stopNow) begin
      heatEn <= 1'b0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

endmodule

// File: rtl/sweep_sync_thermal.sv
`timescale 1ns/1ps
module sweep_sync_thermal
  import sweep_sync_pkg::*;
#(
  parameter int FRAME_LEN = 1124,
  parameter int CNT_W     = 4,
  parameter int TIME_W    = 16,
  parameter int MAX_ON    = 20000,
  localparam int IW       = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic [CNT_W-1:0]  lockFrames,
  input  logic [CNT_W-1:0]  missLimit,
  input  logic              lowContrast,
  input  logic [TIME_W-1:0] heatOnTime,
  output logic              locked,
  output logic [IW-1:0]     byteIdx,
  output logic [3:0]        tempCode,
  output logic              tempValid,
  output logic              heatEn
);

  syncStrobe_t   strobe;
  logic          matchNow, prevSync;

  sync_datapath #(.FRAME_LEN(FRAME_LEN), .IW(IW)) uDp (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .strobe(strobe), .matchNow(matchNow), .prevSync(prevSync),
    .curIdx(byteIdx), .tempCode(tempCode), .tempValid(tempValid)
  );

  sync_control #(.FRAME_LEN(FRAME_LEN), .IW(IW), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .matchNow(matchNow),
    .prevSync(prevSync), .curIdx(byteIdx), .lockFrames(lockFrames),
    .missLimit(missLimit), .strobe(strobe), .locked(locked)
  );

  heater_pulse #(.TIME_W(TIME_W), .MAX_ON(MAX_ON)) uHeat (
    .clk(clk), .rstN(rstN), .locked(locked), .tempValid(tempValid),
    .tempCode(tempCode), .lowContrast(lowContrast), .heatOnTime(heatOnTime),
    .heatEn(heatEn)
  );

endmodule

// File: rtl/sweep_sync_thermal_chk.sv
`timescale 1ns/1ps
module sweep_sync_thermal_chk #(
  parameter int FRAME_LEN = 1124,
  parameter int TIME_W    = 16,
  parameter int MAX_ON    = 20000,
  parameter int IW        = $clog2(FRAME_LEN)
) (
  input logic          clk,
  input logic          rstN,
  input logic          byteValid,
  input logic          locked,
  input logic [IW-1:0] byteIdx,
  input logic          tempValid,
  input logic          heatEn
);

  logic [TIME_W:0] onCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) onCnt <= '0;
    else if (heatEn) onCnt <= onCnt + 1'b1;
    else onCnt <= '0;
  end

  assert_heat_off_unlocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    !locked |=> !heatEn);

  assert_temp_needs_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    tempValid |-> locked);

  assert_idx_holds_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(byteIdx));

  assert_idx_steps_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && locked) |=>
      (byteIdx == (($past(byteIdx) == IW'(FRAME_LEN - 1)) ? '0 : $past(byteIdx) + 1'b1)));

  assert_pulse_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    onCnt <= (TIME_W+1)'(MAX_ON));

endmodule

bind sweep_sync_thermal sweep_sync_thermal_chk #(
  .FRAME_LEN(FRAME_LEN), .TIME_W(TIME_W), .MAX_ON(MAX_ON)
) uChk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .locked(locked),
  .byteIdx(byteIdx), .tempValid(tempValid), .heatEn(heatEn)
);

// File: tb/tb_sweep_sync_thermal.sv
`timescale 1ns/1ps
module tb_sweep_sync_thermal;

  localparam int FRAME_LEN = 1124;
  localparam int CNT_W     = 4;
  localparam int TIME_W    = 16;
  localparam int MAX_ON    = 3000;
  localparam int IW        = $clog2(FRAME_LEN);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              byteValid = 1'b0;
  logic [7:0]        byteIn = 8'h00;
  logic [CNT_W-1:0]  lockFrames = 4'd3;
  logic [CNT_W-1:0]  missLimit = 4'd2;
  logic              lowContrast = 1'b0;
  logic [TIME_W-1:0] heatOnTime = 16'd5000;
  logic              locked, tempValid, heatEn;
  logic [IW-1:0]     byteIdx;
  logic [3:0]        tempCode;

  int nChecks = 0, nFail = 0, hiCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sweep_sync_thermal #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .TIME_W(TIME_W), .MAX_ON(MAX_ON)) dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .lockFrames(lockFrames), .missLimit(missLimit), .lowContrast(lowContrast),
    .heatOnTime(heatOnTime), .locked(locked), .byteIdx(byteIdx),
    .tempCode(tempCode), .tempValid(tempValid), .heatEn(heatEn)
  );

  // Behavioural reference: 0 search, 1 confirming, 2 locked
  int mSt = 0, mIdx = 0, mPrev = 0, mHits = 0, mMiss = 0;
  int mTemp = 8, mTv = 0, mHeat = 0, mTimer = 0, mGoal = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mIdx = 0; mPrev = 0; mHits = 0; mMiss = 0;
      mTemp = 8; mTv = 0; mHeat = 0; mTimer = 0; mGoal = 0;
    end else begin
      int lim, oldTv, oldTemp, oldLock;
      lim = (int'(heatOnTime) > MAX_ON) ? MAX_ON : int'(heatOnTime);
      oldTv = mTv; oldTemp = mTemp; oldLock = (mSt == 2);
      if (!oldLock) begin
        mHeat = 0; mTimer = 0;
      end else if (mHeat == 0) begin
        if (oldTv == 1 && lowContrast && oldTemp <= 13 && lim != 0) begin
          mHeat = 1; mTimer = 1; mGoal = oldTemp + 2;
        end
      end else if ((oldTv == 1 && (oldTemp >= mGoal || oldTemp == 15)) || mTimer >= lim) begin
        mHeat = 0;
      end else begin
        mTimer++;
      end
      mTv = 0;
      if (byteValid) begin
        int isSync, pair, need, allow, nIdx;
        isSync = (byteIn[7:5] == 3'b111 && byteIn[3:0] == 4'h0) ? 1 : 0;
        pair   = isSync & mPrev;
        need   = (lockFrames == 0) ? 1 : int'(lockFrames);
        allow  = (missLimit == 0) ? 1 : int'(missLimit);
        nIdx   = (mIdx == FRAME_LEN - 1) ? 0 : mIdx + 1;
        if (mSt == 0) begin
          if (pair == 1) begin
            nIdx = FRAME_LEN - 2;
            if (need <= 1) begin mSt = 2; mMiss = 0; end
            else begin mSt = 1; mHits = 1; end
          end
        end else if (mSt == 1) begin
          if (mIdx == FRAME_LEN - 3) begin
            if (pair == 0) mSt = 0;
            else if (mHits + 1 >= need) begin mSt = 2; mMiss = 0; end
            else mHits++;
          end
        end else begin
          if (mIdx == FRAME_LEN - 2) begin mTemp = int'(byteIn[3:0]); mTv = 1; end
          if (mIdx == FRAME_LEN - 3) begin
            if (pair == 1) mMiss = 0;
            else if (mMiss + 1 >= allow) mSt = 0;
            else mMiss++;
          end
        end
        mPrev = isSync;
        mIdx = nIdx;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    if (heatEn) hiCnt++;
    chk("R2 locked vs model", int'(locked), (mSt == 2) ? 1 : 0);
    chk("R4 byteIdx vs model", int'(byteIdx), mIdx);
    chk("R5 tempCode vs model", int'(tempCode), mTemp);
    chk("R5 tempValid vs model", int'(tempValid), mTv);
    chk("R7 heatEn vs model", int'(heatEn), mHeat);
  endtask

  task automatic tick(input logic v, input logic [7:0] b);
    @(negedge clk);
    if (rstN) compareAll();
    byteValid = v;
    byteIn = b;
  endtask

  task automatic settle();
    tick(1'b0, 8'h00);
  endtask

  task automatic sendByte(input logic [7:0] b);
    if ($urandom_range(0, 15) == 0) tick(1'b0, 8'h5A);
    tick(1'b1, b);
  endtask

  // One frame: pixel bytes, then marker pair, temperature byte, final byte
  task automatic sendFrame(input int temp, input bit corrupt, input int decoyAt);
    for (int i = 0; i < FRAME_LEN - 4; i++) begin
      logic [7:0] px;
      px = 8'($urandom);
      px[0] = 1'b1;
      if (decoyAt >= 0 && i == decoyAt) px = 8'hF0;
      if (decoyAt >= 0 && i == decoyAt + 1) px = 8'hE0;
      sendByte(px);
    end
    sendByte({3'b111, 1'b1, 4'h0});
    sendByte(corrupt ? 8'h12 : {3'b111, 1'b0, 4'h0});
    sendByte({4'($urandom), 4'(temp)});
    sendByte(8'($urandom));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    chk("R10 reset locked", int'(locked), 0);
    chk("R10 reset byteIdx", int'(byteIdx), 0);
    chk("R10 reset tempCode", int'(tempCode), 8);
    chk("R10 reset tempValid", int'(tempValid), 0);
    chk("R10 reset heatEn", int'(heatEn), 0);

    // R4: 37 unaligned bytes with idle cycles between them
    for (int i = 0; i < 37; i++) begin
      tick(1'b1, 8'h31);
      tick(1'b0, 8'hE0);
    end
    settle();
    chk("R4 index counts valid bytes only", int'(byteIdx), 37);

    // R1 / R2: lock after three frames, bit 4 of the marker ignored
    sendFrame(9, 0, -1); settle();
    chk("R1 aligned after first pair", int'(byteIdx), 0);
    chk("R2 not locked after one pair", int'(locked), 0);
    sendFrame(9, 0, -1); settle();
    chk("R2 not locked after two pairs", int'(locked), 0);
    sendFrame(7, 0, -1); settle();
    chk("R2 locked after three pairs", int'(locked), 1);
    chk("R5 temperature captured", int'(tempCode), 7);

    // R3: decoy marker pair mid-frame while locked
    sendFrame(8, 0, 100); settle();
    chk("R3 lock kept despite decoy", int'(locked), 1);
    chk("R3 index unmoved by decoy", int'(byteIdx), 0);

    // R7 / R8: pulse starts at code 8 and ends on a two-step rise
    lowContrast = 1'b1; heatOnTime = 16'd5000;
    sendFrame(8, 0, -1); settle();
    chk("R7 heater started", int'(heatEn), 1);
    sendFrame(9, 0, -1); settle();
    chk("R8 heater kept below goal", int'(heatEn), 1);
    sendFrame(10, 0, -1); settle();
    chk("R8 heater stopped at goal", int'(heatEn), 0);

    // R9: saturated code never starts a pulse
    sendFrame(15, 0, -1); settle();
    chk("R9 no pulse at code 15", int'(heatEn), 0);
    chk("R5 code 15 captured", int'(tempCode), 15);

    // R8: requested time bounds the pulse
    heatOnTime = 16'd40; hiCnt = 0;
    sendFrame(6, 0, -1); settle();
    lowContrast = 1'b0;
    sendFrame(6, 0, -1); settle();
    chk("R8 pulse length equals request", hiCnt, 40);

    // R8: MAX_ON clips a larger request
    lowContrast = 1'b1; heatOnTime = 16'd60000; hiCnt = 0;
    sendFrame(5, 0, -1); settle();
    lowContrast = 1'b0;
    for (int f = 0; f < 3; f++) begin sendFrame(5, 0, -1); settle(); end
    chk("R8 pulse clipped to MAX_ON", hiCnt, MAX_ON);

    // R6 / R9: one miss tolerated, two drop lock and the heater
    lowContrast = 1'b1; heatOnTime = 16'd5000;
    sendFrame(8, 0, -1); settle();
    lowContrast = 1'b0;
    chk("R7 heater on before loss", int'(heatEn), 1);
    sendFrame(8, 1, -1); settle();
    chk("R6 lock held after one miss", int'(locked), 1);
    sendFrame(8, 1, -1); settle();
    chk("R6 lock dropped after two misses", int'(locked), 0);
    chk("R9 heater off without lock", int'(heatEn), 0);

    // R2: a miss during confirmation restarts the count
    sendFrame(8, 0, -1); settle();
    sendFrame(8, 1, -1); settle();
    sendFrame(8, 0, -1); settle();
    sendFrame(8, 0, -1); settle();
    chk("R2 count restarted after miss", int'(locked), 0);
    sendFrame(8, 0, -1); settle();
    chk("R2 locked after restart", int'(locked), 1);

    // R2: lockFrames of zero behaves as one
    sendFrame(8, 1, -1);
    sendFrame(8, 1, -1); settle();
    chk("R6 lock dropped again", int'(locked), 0);
    lockFrames = 4'd0;
    sendFrame(8, 0, -1); settle();
    chk("R2 zero threshold locks on first pair", int'(locked), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule